// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives an inverter bridge with three PWM phases. Each phase has a true output and a complement output, so there are six pins in total. All phases share one period counter. The counter advances once per tick, and a tick lasts `TICK_DIV` clock cycles. It can count in two ways:

- **Edge-aligned:** a sawtooth that wraps to zero.
- **Center-aligned:** a triangle that climbs to the period value and falls back to zero.

Each phase compares the shared counter against its own duty value. A dead-time stage then makes sure the two outputs of a pair are never on together. When one output of a pair turns off, its partner waits a programmable number of ticks before it turns on.

Software programs the block through a small write port. The period and the three duties are double-buffered. A new value takes effect only at the start of a counting period, so a period is never built from half-old and half-new settings. Dead time, counting mode, per-pin output selection and the port data take effect at once.

Any pin can leave the generator and act as a plain output driven from its port data bit. A synchronous force-off input clears all six pins on the next clock edge, whatever else is set.

Top module: `tri_phase_pwm`

## Requirements
- R1: Phase i drives `pwm_out[2i]` as its true output and `pwm_out[2i+1]` as its complement; all outputs are active high and registered.
- R2: With both pins of a pair taken from the generator, the pair is never high in the same cycle.
- R3: In edge-aligned mode (mode bit 0 = 0) the counter runs 0 to P-1 and wraps, so a period is P ticks; one tick is `TICK_DIV` clocks (2 by default), and the counter never exceeds the active period value.
- R4: In center-aligned mode (mode bit 0 = 1) the counter rises 0 to P and falls back to 1, so a period is 2P ticks; the true output is asserted while the counter is below the duty D, which gives 2D-1 ticks centred on the zero point.
- R5: After either output of a pair goes low, its partner stays low for dead-time × `TICK_DIV` clocks, so each pulse is shortened by that amount (or removed entirely if it is no longer than that); a dead time of 0 makes the two outputs exact complements.
- R6: A duty of 0 keeps the true output low for the whole period and the complement high; a duty of P or more keeps the true output high and the complement low.
- R7: Written period and duty values become active only at the tick on which the counter returns to zero; the active period never changes at any other count.
- R8: When output-select bit k is 1, `pwm_out[k]` follows port-data bit k one cycle later, regardless of the generator.
- R9: Asserting `force_off` makes all six outputs 0 after the next clock edge, overriding both the generator and the port data.
- R10: While `rst_n` is low all six outputs are 0.
- R11: Register addresses are as follows:

  | Address | Register |
  |---|---|
  | 0 | period |
  | 1, 2, 3 | duty of phases 0, 1 and 2 |
  | 4 | dead time in ticks |
  | 5 | mode |
  | 6 | output select (6 bits) |
  | 7 | port data (6 bits) |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| force_off | input | 1 | Synchronous disable of all outputs |
| pwm_out | output | 6 | Pair outputs, true on even bits, complement on odd bits |

## Verification
Two things coincide at the counter's return to zero:

- the buffered duty is loaded, and
- the phase's compare result flips.

So the new duty and the restart of the dead-time count take effect on the same edge. The bench provokes this in two ways. First, it locks onto the start of a period through a one-tick pulse on another phase. Second, it raises a duty from 0 to full mid-period. It then judges that the true output stays low for the rest of that period and is high after the boundary. A second overlap is force-off against port-driven pins, which are all high when the disable arrives. The bench checks that the disable wins on the very next edge.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

  typedef enum logic {
    CNT_EDGE   = 1'b0,
    CNT_CENTER = 1'b1
  } cnt_mode_e;

  // register offsets; duty registers follow OFS_DUTY0 one per phase
  localparam int unsigned OFS_PERIOD = 0;
  localparam int unsigned OFS_DUTY0  = 1;
  localparam int unsigned OFS_AFTER_DUTY_DEAD = 0;
  localparam int unsigned OFS_AFTER_DUTY_MODE = 1;
  localparam int unsigned OFS_AFTER_DUTY_SEL  = 2;
  localparam int unsigned OFS_AFTER_DUTY_PORT = 3;

endpackage

// File: rtl/tpwm_regs.sv
module tpwm_regs
  import tpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 8,
  parameter int NPH    = 3,
  parameter int ADDR_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [CNT_W-1:0]           wr_data,
  input  logic                       load_i,
  output logic [CNT_W-1:0]           per_act,
  output logic [NPH-1:0][CNT_W-1:0]  duty_act,
  output logic [DT_W-1:0]            dt_ticks,
  output cnt_mode_e                  mode,
  output logic [2*NPH-1:0]           out_sel,
  output logic [2*NPH-1:0]           port_val
);

  localparam int NOUT     = 2 * NPH;
  localparam int A_DEAD   = OFS_DUTY0 + NPH + OFS_AFTER_DUTY_DEAD;
  localparam int A_MODE   = OFS_DUTY0 + NPH + OFS_AFTER_DUTY_MODE;
  localparam int A_SEL    = OFS_DUTY0 + NPH + OFS_AFTER_DUTY_SEL;
  localparam int A_PORT   = OFS_DUTY0 + NPH + OFS_AFTER_DUTY_PORT;

  logic [CNT_W-1:0]          per_sh_q, per_sh_d, per_act_q, per_act_d;
  logic [NPH-1:0][CNT_W-1:0] duty_sh_q, duty_sh_d, duty_act_q, duty_act_d;
  logic [DT_W-1:0]           dt_q, dt_d;
  cnt_mode_e                 mode_q, mode_d;
  logic [NOUT-1:0]           sel_q, sel_d, port_q, port_d;

  always_comb begin
    per_sh_d   = per_sh_q;
    duty_sh_d  = duty_sh_q;
    dt_d       = dt_q;
    mode_d     = mode_q;
    sel_d      = sel_q;
    port_d     = port_q;
    if (wr_en) begin
      if (wr_addr == ADDR_W'(OFS_PERIOD)) per_sh_d = wr_data;
      for (int i = 0; i < NPH; i++) begin
        if (wr_addr == ADDR_W'(OFS_DUTY0 + i)) duty_sh_d[i] = wr_data;
      end
      if (wr_addr == ADDR_W'(A_DEAD)) dt_d   = wr_data[DT_W-1:0];
      if (wr_addr == ADDR_W'(A_MODE)) mode_d = cnt_mode_e'(wr_data[0]);
      if (wr_addr == ADDR_W'(A_SEL))  sel_d  = wr_data[NOUT-1:0];
      if (wr_addr == ADDR_W'(A_PORT)) port_d = wr_data[NOUT-1:0];
    end
  end

  // buffered values move to the active set only at a period boundary
  always_comb begin
    per_act_d  = per_act_q;
    duty_act_d = duty_act_q;
    if (load_i) begin
      per_act_d  = per_sh_q;
      duty_act_d = duty_sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh_q   <= '0;
      duty_sh_q  <= '0;
      per_act_q  <= '0;
      duty_act_q <= '0;
      dt_q       <= '0;
      mode_q     <= CNT_EDGE;
      sel_q      <= '0;
      port_q     <= '0;
    end else begin
      per_sh_q   <= per_sh_d;
      duty_sh_q  <= duty_sh_d;
      per_act_q  <= per_act_d;
      duty_act_q <= duty_act_d;
      dt_q       <= dt_d;
      mode_q     <= mode_d;
      sel_q      <= sel_d;
      port_q     <= port_d;
    end
  end

  assign per_act  = per_act_q;
  assign duty_act = duty_act_q;
  assign dt_ticks = dt_q;
  assign mode     = mode_q;
  assign out_sel  = sel_q;
  assign port_val = port_q;

endmodule

// File: rtl/tpwm_timebase.sv
module tpwm_timebase
  import tpwm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] per_act,
  output logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             boundary
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] pre_q, pre_d;
      always_comb begin
        if (pre_q == PRE_W'(TICK_DIV - 1)) pre_d = '0;
        else                               pre_d = pre_q + PRE_W'(1);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end
      assign tick = (pre_q == PRE_W'(TICK_DIV - 1));
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic             wrap;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    wrap  = 1'b0;
    if (tick) begin
      if (mode == CNT_EDGE) begin
        up_d = 1'b1;
        if (cnt_inc >= {1'b0, per_act}) begin
          wrap  = 1'b1;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end else if (per_act == '0) begin
        wrap  = 1'b1;
        cnt_d = '0;
        up_d  = 1'b1;
      end else if (up_q) begin
        cnt_d = cnt_inc[CNT_W-1:0];
        if (cnt_inc >= {1'b0, per_act}) up_d = 1'b0;
      end else if (cnt_q <= CNT_W'(1)) begin
        wrap  = 1'b1;
        cnt_d = '0;
        up_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt      = cnt_q;
  assign boundary = wrap;

endmodule

// File: rtl/tpwm_phase.sv
module tpwm_phase #(
  parameter int CNT_W    = 16,
  parameter int DT_W     = 8,
  parameter int TICK_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] per_act,
  input  logic [CNT_W-1:0] duty,
  input  logic [DT_W-1:0]  dt_ticks,
  output logic             hi,
  output logic             lo
);

  localparam int DTC_W = DT_W + $clog2(TICK_DIV) + 1;

  logic             raw;
  logic             raw_q, raw_d;
  logic [DTC_W-1:0] dtc_q, dtc_d;
  logic [DTC_W-1:0] dt_load;

  assign raw     = (duty != '0) && ((duty >= per_act) || (cnt < duty));
  assign dt_load = DTC_W'(dt_ticks) * DTC_W'(TICK_DIV);

  // any change of the compare result restarts the guard interval
  always_comb begin
    raw_d = raw;
    dtc_d = dtc_q;
    if (raw != raw_q)        dtc_d = dt_load;
    else if (dtc_q != '0)    dtc_d = dtc_q - DTC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      dtc_q <= '0;
    end else begin
      raw_q <= raw_d;
      dtc_q <= dtc_d;
    end
  end

  assign hi = raw_q  && (dtc_q == '0);
  assign lo = !raw_q && (dtc_q == '0);

endmodule

// File: rtl/tri_phase_pwm.sv
module tri_phase_pwm
  import tpwm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DT_W     = 8,
  parameter int TICK_DIV = 2,
  parameter int NPH      = 3,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  input  logic                force_off,
  output logic [2*NPH-1:0]    pwm_out
);

  localparam int NOUT = 2 * NPH;

  logic [CNT_W-1:0]          per_act;
  logic [NPH-1:0][CNT_W-1:0] duty_act;
  logic [DT_W-1:0]           dt_ticks;
  cnt_mode_e                 mode;
  logic [NOUT-1:0]           out_sel, port_val;
  logic                      tick, boundary;
  logic [CNT_W-1:0]          cnt;
  logic [NPH-1:0]            gen_hi, gen_lo;
  logic [NOUT-1:0]           gen_pins;
  logic [NOUT-1:0]           out_q, out_d;

  tpwm_regs #(
    .CNT_W (CNT_W),
    .DT_W  (DT_W),
    .NPH   (NPH),
    .ADDR_W(ADDR_W)
  ) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .load_i  (boundary),
    .per_act (per_act),
    .duty_act(duty_act),
    .dt_ticks(dt_ticks),
    .mode    (mode),
    .out_sel (out_sel),
    .port_val(port_val)
  );

  tpwm_timebase #(
    .CNT_W   (CNT_W),
    .TICK_DIV(TICK_DIV)
  ) i_timebase (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .per_act (per_act),
    .tick    (tick),
    .cnt     (cnt),
    .boundary(boundary)
  );

  generate
    for (genvar p = 0; p < NPH; p++) begin : g_phase
      tpwm_phase #(
        .CNT_W   (CNT_W),
        .DT_W    (DT_W),
        .TICK_DIV(TICK_DIV)
      ) i_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt),
        .per_act (per_act),
        .duty    (duty_act[p]),
        .dt_ticks(dt_ticks),
        .hi      (gen_hi[p]),
        .lo      (gen_lo[p])
      );
      assign gen_pins[2*p]   = gen_hi[p];
      assign gen_pins[2*p+1] = gen_lo[p];
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < NOUT; k++) begin
      if (force_off)       out_d[k] = 1'b0;
      else if (out_sel[k]) out_d[k] = port_val[k];
      else                 out_d[k] = gen_pins[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign pwm_out = out_q;

  // tick is consumed inside the timebase; kept visible for the checker
  logic tick_seen;
  assign tick_seen = tick;

endmodule

// File: rtl/tpwm_checker.sv
module tpwm_checker #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8,
  parameter int NPH   = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                force_off,
  input logic [2*NPH-1:0]    pwm_out,
  input logic [2*NPH-1:0]    out_sel,
  input logic [2*NPH-1:0]    port_val,
  input logic [CNT_W-1:0]    per_act,
  input logic [CNT_W-1:0]    cnt,
  input logic [NPH-1:0]      gen_hi,
  input logic [NPH-1:0]      gen_lo,
  input logic [DT_W-1:0]     dt_ticks,
  input logic                tick_seen
);

  AST_CNT_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_act); // R3

  AST_ACTIVE_LOADS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act != $past(per_act)) |-> (cnt == '0)); // R7

  AST_FORCE_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (pwm_out == '0)); // R9

  AST_CNT_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_seen |=> $stable(cnt)); // R3

  generate
    for (genvar k = 0; k < 2*NPH; k++) begin : g_pin
      AST_PORT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_off && out_sel[k]) |=> (pwm_out[k] == $past(port_val[k]))); // R8
    end
    for (genvar p = 0; p < NPH; p++) begin : g_pair
      AST_PAIR_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_off && !out_sel[2*p] && !out_sel[2*p+1])
          |=> !(pwm_out[2*p] && pwm_out[2*p+1])); // R2
      AST_DEAD_GAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gen_hi[p]) && ($past(dt_ticks) != '0)) |-> !gen_lo[p]); // R5
      AST_DEAD_GAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gen_lo[p]) && ($past(dt_ticks) != '0)) |-> !gen_hi[p]); // R5
    end
  endgenerate

endmodule

bind tri_phase_pwm tpwm_checker #(
  .CNT_W(CNT_W),
  .DT_W (DT_W),
  .NPH  (NPH)
) i_tpwm_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .force_off(force_off),
  .pwm_out  (pwm_out),
  .out_sel  (out_sel),
  .port_val (port_val),
  .per_act  (per_act),
  .cnt      (cnt),
  .gen_hi   (gen_hi),
  .gen_lo   (gen_lo),
  .dt_ticks (dt_ticks),
  .tick_seen(tick_seen)
);

// File: tb/test_tri_phase_pwm.sv
module test_tri_phase_pwm;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        force_off;
  logic [5:0]  pwm_out;

  int n_chk;
  int n_err;
  int hi_n [3];
  int lo_n [3];
  int ovl_n;

  tri_phase_pwm i_tri_phase_pwm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .force_off(force_off),
    .pwm_out  (pwm_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [15:0] mode;
    logic [15:0] per;
    logic [15:0] d0;
    logic [15:0] d1;
    logic [15:0] d2;
    logic [15:0] dt;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{16'd0, 16'd20, 16'd5,  16'd10, 16'd0,  16'd2},
    '{16'd1, 16'd16, 16'd4,  16'd16, 16'd20, 16'd1},
    '{16'd0, 16'd12, 16'd12, 16'd1,  16'd3,  16'd0},
    '{16'd0, 16'd10, 16'd2,  16'd9,  16'd5,  16'd3},
    '{16'd1, 16'd8,  16'd1,  16'd5,  16'd0,  16'd2}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 3'(addr);
    wr_data = 16'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // expected clocks high per period for true (hi) and complement (lo)
  function automatic void expect_counts(input int mode, input int per, input int d,
                                        input int dt, output int e_hi, output int e_lo,
                                        output int clk_per);
    int t, h, n;
    t = (mode != 0) ? 2 * per : per;
    if (d == 0)        h = 0;
    else if (d >= per) h = t;
    else               h = (mode != 0) ? 2 * d - 1 : d;
    n = 2 * dt;
    clk_per = 2 * t;
    if (h == 0) begin
      e_hi = 0; e_lo = 2 * t;
    end else if (h == t) begin
      e_hi = 2 * t; e_lo = 0;
    end else begin
      e_hi = (2 * h > n) ? 2 * h - n : 0;
      e_lo = (2 * (t - h) > n) ? 2 * (t - h) - n : 0;
    end
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; force_off = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 outputs in reset", int'(pwm_out), 0);
    rst_n = 1'b1;

    // R11: map 0 period, 1..3 duties, 4 dead, 5 mode, 6 select, 7 port
    for (int v = 0; v < NV; v++) begin
      int e_hi, e_lo, cp, dsel;
      wr(5, int'(VEC[v].mode));
      wr(4, int'(VEC[v].dt));
      wr(0, int'(VEC[v].per));
      wr(1, int'(VEC[v].d0));
      wr(2, int'(VEC[v].d1));
      wr(3, int'(VEC[v].d2));
      repeat (600) @(negedge clk);
      expect_counts(int'(VEC[v].mode), int'(VEC[v].per), 0, 0, e_hi, e_lo, cp);
      for (int i = 0; i < 3; i++) begin hi_n[i] = 0; lo_n[i] = 0; end
      ovl_n = 0;
      for (int c = 0; c < cp; c++) begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
          if (pwm_out[2*i])   hi_n[i]++;
          if (pwm_out[2*i+1]) lo_n[i]++;
          if (pwm_out[2*i] && pwm_out[2*i+1]) ovl_n++;
        end
      end
      for (int i = 0; i < 3; i++) begin
        dsel = (i == 0) ? int'(VEC[v].d0) : (i == 1) ? int'(VEC[v].d1) : int'(VEC[v].d2);
        expect_counts(int'(VEC[v].mode), int'(VEC[v].per), dsel, int'(VEC[v].dt),
                      e_hi, e_lo, cp);
        // R1 R3 R4 R5 R6: pulse widths per pin over one period
        check($sformatf("R1/R3/R4/R5/R6 vec%0d phase%0d true width", v, i), hi_n[i], e_hi);
        check($sformatf("R1/R3/R4/R5/R6 vec%0d phase%0d complement width", v, i), lo_n[i], e_lo);
      end
      check($sformatf("R2 vec%0d overlap cycles", v), ovl_n, 0);
    end

    // R8 and R9: port-driven pins, then force-off overriding them
    wr(7, 6'h3F);
    wr(6, 6'h3F);
    @(negedge clk);
    check("R8 all pins from port data", int'(pwm_out), 6'h3F);
    force_off = 1'b1;
    @(negedge clk);
    check("R9 force_off clears on next edge", int'(pwm_out), 0);
    repeat (5) @(negedge clk);
    check("R9 force_off held", int'(pwm_out), 0);
    force_off = 1'b0;
    wr(7, 6'h01);
    wr(6, 6'h03);
    @(negedge clk);
    check("R8 pair 0 from port 01", int'(pwm_out[1:0]), 1);
    wr(7, 6'h02);
    @(negedge clk);
    check("R8 pair 0 from port 10", int'(pwm_out[1:0]), 2);
    wr(6, 0);

    // R7: duty written mid-period waits for the boundary
    wr(5, 0);
    wr(4, 0);
    wr(0, 40);
    wr(1, 0);
    wr(2, 1);
    wr(3, 0);
    repeat (400) @(negedge clk);
    begin
      int prev, found, seen_hi;
      prev = 1; found = 0;
      for (int c = 0; c < 200 && found == 0; c++) begin
        @(negedge clk);
        if (pwm_out[2] && prev == 0) found = 1;
        prev = int'(pwm_out[2]);
      end
      check("R7 period start found", found, 1);
      wr(1, 40);
      seen_hi = 0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (pwm_out[0]) seen_hi++;
      end
      check("R7 new duty not applied before boundary", seen_hi, 0);
      repeat (40) @(negedge clk);
      check("R7 new duty applied after boundary", int'(pwm_out[0]), 1);
      check("R6 full duty complement low", int'(pwm_out[1]), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule